// File: doc/BRIEF.md
# I2C Register-Pair Target

This block is the two-wire serial target for a 16-bit port expander. The registers behind it sit in pairs, each pair holding the two byte halves of one 16-bit quantity. The controller addresses the target with its 7-bit bus address and sends a command byte that sets an internal register pointer. It can then write data bytes, or issue a repeated start with the read direction to fetch bytes.

Every data byte in either direction goes to or comes from the register under the pointer. After each data byte, bit 0 of the pointer flips, so a transfer of any length bounces between the two registers of one pair. After every acknowledged ninth clock, the target holds SCL low for a fixed number of system clocks while it fetches or commits a register. This gives the bus the idle gap it needs after each byte.

Both bus lines are sampled through synchronizer flip-flops. Each output is an active-low pull enable for an open-drain pad, so a high level means the line is released.

Top module: `pairx_i2c_target`

## Requirements
- R1: Out of reset both pull enables are high (lines released) and every register of the file reads back as 0x00.
- R2: An address byte whose upper seven bits equal DEV_ADDR is acknowledged by pulling SDA low during the ninth clock. A non-matching address is not acknowledged, and the target then drives neither line until the next start condition.
- R3: After a matching address with R/W bit 0 (bit 0 of the address byte), the next byte is acknowledged and loaded as the pointer. Only its low log2(2*PAIRS) bits index a register, and bit 0 picks the register within a pair.
- R4: Each further byte of a write transfer is acknowledged and stored in the register under the pointer, after which pointer bit 0 flips.
- R5: After a repeated start and the address with R/W bit 1, the first byte sent, MSB first, is the register under the pointer.
- R6: Each read byte the controller acknowledges is followed by the other register of the same pair, alternating without limit.
- R7: A controller NACK on a read byte ends the transfer. The target releases SDA and drives neither line until the next start. Pointer bit 0 still flips after that byte.
- R8: After every acknowledged ninth-clock falling edge, the target pulls SCL low for exactly STRETCH_CYCLES system clocks. No stretch follows a NACKed byte or a non-matching address.
- R9: A stop condition ends a transfer and keeps the pointer. A later read with no command byte starts at the register following the last one written.
- R10: The target changes its SDA pull only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| scl_pull_n | output | 1 | Low pulls SCL to ground (clock stretch) |
| sda_pull_n | output | 1 | Low pulls SDA to ground (ACK or data 0) |

## Verification
The embedded assertions watch properties that hold on every cycle:
- SDA moves only while SCL is low.
- A stretch starts only from an acknowledged ninth clock.
- An address acknowledge appears only for a matching address.
- A register write happens only while the target is acknowledging.
- The pointer toggles after every read byte.
- SDA stays released while idle.

Data values and the alternation order over long reads can only be shown by the bench's transfers. The same holds for the exact stretch length, silence after a NACK or a foreign address, and a pointer carried across a stop. The bench compares these against its own model of the register file and pointer.

// File: rtl/pxi_pkg.sv
package pxi_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WR,
    PH_RD
  } phase_e;

  // true when the upper seven bits of a received address byte name this target
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] dev);
    return rx[7:1] == dev;
  endfunction

  // pair partner of a pointer value: only the in-pair select bit changes
  function automatic logic [7:0] flip_sel(input logic [7:0] p);
    return {p[7:1], ~p[0]};
  endfunction

endpackage

// File: rtl/pxi_line_sync.sv
module pxi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_prev;
  logic              sda_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_prev;
  assign scl_fall = ~scl_s & scl_prev;
  assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/pxi_stretch.sv
module pxi_stretch #(
  parameter int CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic hold
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign hold = cnt != '0;

  // R8: a hold window opens only from a trigger
  p_hold_from_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(trig));

endmodule

// File: rtl/pxi_pair_regs.sv
module pxi_pair_regs #(
  parameter int PAIRS = 4,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [$clog2(2*PAIRS)-1:0]   waddr,
  input  logic [DW-1:0]                wdata,
  input  logic [$clog2(2*PAIRS)-1:0]   raddr,
  output logic [DW-1:0]                rdata
);

  localparam int REGS = 2 * PAIRS;
  localparam int IW   = $clog2(REGS);

  logic [DW-1:0] regs [REGS];

  generate
    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
      localparam logic [IW-1:0] LO = IW'(2 * g);
      localparam logic [IW-1:0] HI = IW'(2 * g + 1);
      logic [DW-1:0] lo_q;
      logic [DW-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
        end else if (we) begin
          if (waddr == LO) lo_q <= wdata;
          if (waddr == HI) hi_q <= wdata;
        end
      end
      assign regs[2*g]   = lo_q;
      assign regs[2*g+1] = hi_q;
    end
  endgenerate

  assign rdata = regs[raddr];

endmodule

// File: rtl/pairx_i2c_target.sv
module pairx_i2c_target #(
  parameter logic [6:0] DEV_ADDR       = 7'h27,
  parameter int         PAIRS          = 4,
  parameter int         STRETCH_CYCLES = 3000,
  parameter int         SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_n,
  output logic sda_pull_n
);
  import pxi_pkg::*;

  localparam int REGS = 2 * PAIRS;
  localparam int IW   = $clog2(REGS);
  localparam logic [3:0] ACK_SLOT  = 4'd8;
  localparam logic [3:0] LAST_SLOT = 4'd9;

  // synchronized line events
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  pxi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  phase_e     phase;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic [7:0] ptr;
  logic       sda_drv;
  logic       ctl_nack;

  // named internal events
  logic       bus_ev, eighth_fall, ninth_fall, byte_acked, rf_we;
  logic [7:0] rd_ptr;
  logic [7:0] rf_rdata;

  assign bus_ev      = start_ev | stop_ev;
  assign eighth_fall = scl_fall && !bus_ev && phase != PH_IDLE && bit_cnt == ACK_SLOT;
  assign ninth_fall  = scl_fall && !bus_ev && phase != PH_IDLE && bit_cnt == LAST_SLOT;
  assign byte_acked  = ninth_fall && (phase != PH_RD || !ctl_nack);
  assign rf_we       = ninth_fall && phase == PH_WR;
  assign rd_ptr      = (phase == PH_RD) ? flip_sel(ptr) : ptr;

  pxi_pair_regs #(.PAIRS(PAIRS), .DW(8)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (ptr[IW-1:0]),
    .wdata (rx_sh),
    .raddr (rd_ptr[IW-1:0]),
    .rdata (rf_rdata)
  );

  logic hold;

  pxi_stretch #(.CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (byte_acked),
    .hold  (hold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      sda_drv  <= 1'b0;
      ctl_nack <= 1'b0;
    end else if (start_ev) begin
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      sda_drv <= 1'b0;
    end else if (stop_ev) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      sda_drv <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt < ACK_SLOT) rx_sh <= {rx_sh[6:0], sda_s};
        else                    ctl_nack <= sda_s;
        if (bit_cnt < LAST_SLOT) bit_cnt <= bit_cnt + 1'b1;
      end else if (eighth_fall) begin
        case (phase)
          PH_ADDR: begin
            if (addr_hit(rx_sh, DEV_ADDR)) sda_drv <= 1'b1;
            else begin
              phase   <= PH_IDLE;
              bit_cnt <= '0;
            end
          end
          PH_CMD, PH_WR: sda_drv <= 1'b1;
          default:       sda_drv <= 1'b0;
        endcase
      end else if (ninth_fall) begin
        bit_cnt <= '0;
        sda_drv <= 1'b0;
        case (phase)
          PH_ADDR: begin
            if (rx_sh[0]) begin
              phase   <= PH_RD;
              tx_sh   <= rf_rdata;
              sda_drv <= ~rf_rdata[7];
            end else begin
              phase <= PH_CMD;
            end
          end
          PH_CMD: begin
            ptr   <= rx_sh;
            phase <= PH_WR;
          end
          PH_WR: ptr <= flip_sel(ptr);
          PH_RD: begin
            ptr <= flip_sel(ptr);
            if (ctl_nack) begin
              phase <= PH_IDLE;
            end else begin
              tx_sh   <= rf_rdata;
              sda_drv <= ~rf_rdata[7];
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end else if (scl_fall && phase == PH_RD && bit_cnt != '0 && bit_cnt < ACK_SLOT) begin
        tx_sh   <= {tx_sh[6:0], 1'b0};
        sda_drv <= ~tx_sh[6];
      end
    end
  end

  assign sda_pull_n = ~sda_drv;
  assign scl_pull_n = ~hold;

  // R10: the data pull moves only after SCL was seen low
  p_sda_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_n) |-> $past(!scl_s));

  // R8: a clock stretch begins only after an acknowledged ninth clock
  p_stretch_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull_n) |-> $past(byte_acked));

  // R2: an address acknowledge is given only to a matching address
  p_ack_only_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull_n) && $past(phase) == PH_ADDR) |-> $past(rx_sh[7:1]) == DEV_ADDR);

  // R4: a register is committed only while the target acknowledges the byte
  p_write_while_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !sda_pull_n);

  // R6: the pointer flips within its pair after every read byte
  p_ptr_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ninth_fall && phase == PH_RD) |=> ptr[0] != $past(ptr[0]));

  // R7: SDA stays released while the target is idle
  p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IDLE |-> sda_pull_n);

endmodule

// File: tb/pairx_i2c_target_tb.sv
`timescale 1ns/1ps
module pairx_i2c_target_tb;

  localparam logic [6:0] ADDR  = 7'h27;
  localparam int PAIRS   = 4;
  localparam int NREG    = 2 * PAIRS;
  localparam int STRETCH = 20;
  localparam int Q       = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic scl_pull_n, sda_pull_n;
  wire  scl_i = scl_m & scl_pull_n;
  wire  sda_i = sda_m & sda_pull_n;

  always #2 clk = ~clk;

  pairx_i2c_target #(.DEV_ADDR(ADDR), .PAIRS(PAIRS), .STRETCH_CYCLES(STRETCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_pull_n(scl_pull_n), .sda_pull_n(sda_pull_n));

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [NREG];
  logic [7:0] mptr;
  logic [7:0] wbuf [16];
  int stretch_cnt = 0;
  int run = 0;
  bit silent_win = 0;
  int silent_bad = 0;
  logic prev_sda = 1'b1;

  function automatic int idx_of(input logic [7:0] p);
    return int'(p) % NREG;
  endfunction

  function automatic logic [7:0] partner(input logic [7:0] p);
    return p[0] ? p - 8'd1 : p + 8'd1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitors: stretch length (R8), SDA timing (R10), silence windows (R2, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (!scl_pull_n) run++;
      else if (run != 0) begin
        check(run == STRETCH, "R8 stretch length", run, STRETCH);
        stretch_cnt++;
        run = 0;
      end
      if (sda_pull_n !== prev_sda) check(!scl_i, "R10 SDA moved with SCL high", 1, 0);
      prev_sda = sda_pull_n;
      if (silent_win && (!sda_pull_n || !scl_pull_n)) silent_bad++;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_i) @(negedge clk);
    wait_n(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_n(Q); scl_up(); scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_n(Q); scl_up(); b = sda_i; scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(Q); scl_up(); sda_m = 1'b0; wait_n(Q); scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(Q); scl_up(); sda_m = 1'b1; wait_n(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output bit acked);
    logic r;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(r);
    acked = !r;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!ack);
  endtask

  task automatic do_write(input logic [7:0] cmd, input int n);
    bit a;
    int s0 = stretch_cnt;
    bus_start();
    put_byte({ADDR, 1'b0}, a); check(a, "R2 address ack", a, 1);
    put_byte(cmd, a);          check(a, "R3 command ack", a, 1);
    mptr = cmd;
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], a);    check(a, "R4 data ack", a, 1);
      mem[idx_of(mptr)] = wbuf[i];
      mptr = partner(mptr);
    end
    bus_stop();
    check(stretch_cnt - s0 == n + 2, "R8 stretch count write", stretch_cnt - s0, n + 2);
  endtask

  task automatic do_read(input bit use_cmd, input logic [7:0] cmd, input int n);
    bit a;
    logic [7:0] d;
    int s0 = stretch_cnt;
    int exp_s = use_cmd ? n + 2 : n;
    bus_start();
    if (use_cmd) begin
      put_byte({ADDR, 1'b0}, a); check(a, "R2 address ack", a, 1);
      put_byte(cmd, a);          check(a, "R3 command ack", a, 1);
      mptr = cmd;
      bus_start();
    end
    put_byte({ADDR, 1'b1}, a);   check(a, "R5 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(d, i < n - 1);
      if (i == 0) check(d == mem[idx_of(mptr)], "R5 first read byte", d, mem[idx_of(mptr)]);
      else        check(d == mem[idx_of(mptr)], "R6 alternating read byte", d, mem[idx_of(mptr)]);
      mptr = partner(mptr);
    end
    silent_bad = 0; silent_win = 1;
    wait_n(40);
    silent_win = 0;
    check(silent_bad == 0, "R7 released after NACK", silent_bad, 0);
    bus_stop();
    check(stretch_cnt - s0 == exp_s, "R8 stretch count read", stretch_cnt - s0, exp_s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    void'($urandom(32'h5A17));
    for (int i = 0; i < NREG; i++) mem[i] = 8'h00;
    mptr = 8'h00;
    wait_n(5);
    check(scl_pull_n && sda_pull_n, "R1 lines released in reset", {scl_pull_n, sda_pull_n}, 3);
    rst_n = 1'b1;
    wait_n(5);
    check(scl_pull_n && sda_pull_n, "R1 lines released after reset", {scl_pull_n, sda_pull_n}, 3);

    // R1: registers read back zero after reset
    do_read(1, 8'h00, 4);
    do_read(1, 8'h06, 2);

    // R4 overwrite through alternation, then R5/R6 readback from the high half
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    do_write(8'h02, 3);
    do_read(1, 8'h03, 3);

    // R2: foreign address gets no ACK and no activity
    silent_bad = 0; silent_win = 1;
    bus_start();
    put_byte({7'h26, 1'b0}, a); check(!a, "R2 foreign address not acked", a, 0);
    put_byte(8'h02, a);         check(!a, "R2 later byte ignored", a, 0);
    put_byte(8'h55, a);         check(!a, "R2 later byte ignored", a, 0);
    bus_stop();
    silent_win = 0;
    check(silent_bad == 0, "R2 target silent", silent_bad, 0);
    do_read(1, 8'h02, 2);

    // R3: upper command bits do not change the index
    wbuf[0] = 8'h3C;
    do_write(8'hFD, 1);
    do_read(1, 8'h05, 1);

    // R9: pointer survives a stop, read without command
    wbuf[0] = 8'h81;
    do_write(8'h06, 1);
    do_read(0, 8'h00, 2);

    // R6: long alternating read
    do_read(1, 8'h05, 12);

    // random mix
    for (int t = 0; t < 20; t++) begin
      int kind = $urandom_range(0, 2);
      int n;
      if (kind == 0) begin
        n = $urandom_range(1, 4);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom_range(0, 255));
        do_write(8'($urandom_range(0, 255)), n);
      end else if (kind == 1) begin
        do_read(1, 8'($urandom_range(0, 255)), $urandom_range(1, 6));
      end else begin
        do_read(0, 8'h00, $urandom_range(1, 4));
      end
    end

    wait_n(20);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule